// File: doc/BRIEF.md
# Vertical-Scroll Scanline Counter

This block keeps count of the scanlines spent on the current mode line of a display list while fine vertical scrolling is in effect. Each new instruction loads a 4-bit scanline counter and latches the mode's last-line value. At every end-of-scanline strobe the counter is compared with an end value. On a match the block raises a request for the next instruction. Otherwise the counter steps by one and wraps from 15 to 0. A flag marks the first scanline of the mode line. That is the only scanline on which screen memory is fetched, however often the line is then repeated.

The start and end values depend on where the line sits in a scrolled region:

- **Head:** the first line with scrolling enabled starts from the scroll register.
- **Tail:** the first unscrolled line after a scrolled run ends when the counter equals the scroll register.

The tail comparison reads the register live. Because the counter wraps, a scroll value beyond the mode's height can stretch a line to as many as 16 scanlines.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `vscroll_line_counter`

## Requirements
- R1: After reset, `line_cnt` is 0, `fetch_next` is 1 and `fetch_data` is 0.
- R2: A `new_instr` strobe on a plain, body or tail line sets `line_cnt` to 0 on the next cycle, and drops `fetch_next` to 0 on that same cycle.
- R3: A `new_instr` strobe on a head line loads `line_cnt` with the value `vscroll` holds in the strobe cycle. A head line is one where `scroll_en` is 1 and the previous load had it 0.
- R4: On an `eol` strobe while `fetch_next` is 0, if `line_cnt` equals the end value, `fetch_next` becomes 1 and `line_cnt` holds. Otherwise `line_cnt` increments modulo 16, so 15 is followed by 0.
- R5: The end value is the latched `mode_last` on plain, head and body lines. On a tail line (`scroll_en` 0 after a load with it 1) the end value is the current `vscroll`, sampled at each `eol`, so a mid-line write changes the line's length.
- R6: `fetch_data` is 1 from the cycle after `new_instr` until the first `eol` of that mode line, and 0 otherwise.
- R7: While `fetch_next` is 1, `eol` strobes have no effect: `line_cnt` and `fetch_next` stay unchanged.
- R8: The head/tail decision uses the `scroll_en` value of the previous load. Reset counts as a previous value of 0.
- R9: When `new_instr` and `eol` arrive in the same cycle, the load wins and the `eol` is discarded.
- R10: A mode line lasts ((end − start) mod 16) + 1 scanlines. For example, with `mode_last` 0 and `vscroll` 13, a head line lasts 4 scanlines and the following tail line lasts 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| new_instr | input | 1 | Strobe: a new mode line starts (load) |
| scroll_en | input | 1 | Vertical-scroll bit of the new instruction |
| mode_last | input | 4 | Last scanline value of the new mode |
| vscroll | input | 4 | Fine vertical scroll register |
| eol | input | 1 | End-of-scanline strobe |
| line_cnt | output | 4 | Current scanline counter |
| fetch_next | output | 1 | Request for the next display-list instruction (level) |
| fetch_data | output | 1 | High on the first scanline of a mode line |

## Verification
Every scroll value from 0 to 15 is driven through a head, body and tail sequence, with the mode height chosen at random. This separates start-from-scroll, end-at-scroll and normal counting, and it reaches the wrap path whenever the scroll value exceeds the height. Random runs of instructions mix all four region kinds. Directed cases then cover the remaining behaviours:

- a scroll write in the middle of a tail line, which shows the end value is sampled live;
- end-of-line strobes sent while a request is pending;
- a load that coincides with an end-of-line strobe.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  localparam int unsigned CNT_W = 4;

  typedef enum logic [1:0] {
    SEG_PLAIN = 2'd0,
    SEG_HEAD  = 2'd1,
    SEG_BODY  = 2'd2,
    SEG_TAIL  = 2'd3
  } seg_e;
endpackage

// File: rtl/vsc_segment.sv
// Classifies each load into plain/head/body/tail and supplies start and end values.
module vsc_segment
  import vsc_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          scroll_en,
  input  logic [CW-1:0] mode_last,
  input  logic [CW-1:0] vscroll,
  output logic [CW-1:0] start_val,
  output logic [CW-1:0] end_val
);
  logic          prev_en_q;
  seg_e          seg_q, seg_d;
  logic [CW-1:0] last_q;

  always_comb begin
    unique case ({prev_en_q, scroll_en})
      2'b01:   seg_d = SEG_HEAD;
      2'b11:   seg_d = SEG_BODY;
      2'b10:   seg_d = SEG_TAIL;
      default: seg_d = SEG_PLAIN;
    endcase
    // head lines start from the scroll register (R3)
    start_val = (seg_d == SEG_HEAD) ? vscroll : '0;
    // tail lines end on the live scroll register (R5)
    end_val   = (seg_q == SEG_TAIL) ? vscroll : last_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_en_q <= 1'b0;  // R8
      seg_q     <= SEG_PLAIN;
      last_q    <= '0;
    end else if (load) begin
      prev_en_q <= scroll_en;
      seg_q     <= seg_d;
      last_q    <= mode_last;
    end
  end
endmodule

// File: rtl/vsc_count.sv
// Wrapping scanline counter with end compare.
module vsc_count
  import vsc_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [CW-1:0] start_val,
  input  logic [CW-1:0] end_val,
  output logic [CW-1:0] cnt,
  output logic          hit
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  assign hit = (cnt == end_val);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= start_val;
    else if (step && !hit)
      cnt <= cnt + ONE;  // wraps modulo 2**CW (R4)
  end
endmodule

// File: rtl/vsc_phase.sv
// Request and first-scanline flags.
module vsc_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  input  logic hit,
  output logic req,
  output logic first
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req   <= 1'b1;
      first <= 1'b0;
    end else if (load) begin
      req   <= 1'b0;
      first <= 1'b1;
    end else if (step) begin
      first <= 1'b0;
      if (hit) req <= 1'b1;
    end
  end
endmodule

// File: rtl/vscroll_line_counter.sv
module vscroll_line_counter
  import vsc_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          new_instr,
  input  logic          scroll_en,
  input  logic [CW-1:0] mode_last,
  input  logic [CW-1:0] vscroll,
  input  logic          eol,
  output logic [CW-1:0] line_cnt,
  output logic          fetch_next,
  output logic          fetch_data
);
  logic [CW-1:0] start_val, end_val;
  logic          hit, step;

  // load wins over eol (R9); eol ignored while a request is pending (R7)
  assign step = eol && !new_instr && !fetch_next;

  vsc_segment #(.CW(CW)) u_seg (
    .clk(clk), .rst_n(rst_n), .load(new_instr), .scroll_en(scroll_en),
    .mode_last(mode_last), .vscroll(vscroll),
    .start_val(start_val), .end_val(end_val)
  );

  vsc_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(new_instr), .step(step),
    .start_val(start_val), .end_val(end_val), .cnt(line_cnt), .hit(hit)
  );

  vsc_phase u_phase (
    .clk(clk), .rst_n(rst_n), .load(new_instr), .step(step), .hit(hit),
    .req(fetch_next), .first(fetch_data)
  );
endmodule

// File: rtl/vsc_checker.sv
module vsc_checker #(
  parameter int unsigned CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          new_instr,
  input logic          scroll_en,
  input logic [CW-1:0] mode_last,
  input logic [CW-1:0] vscroll,
  input logic          eol,
  input logic [CW-1:0] line_cnt,
  input logic          fetch_next,
  input logic          fetch_data
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else if (new_instr) prev_q <= scroll_en;
  end

  p_load_clears_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    new_instr |=> !fetch_next && fetch_data);

  p_plain_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    new_instr && !(scroll_en && !prev_q) |=> line_cnt == '0);

  p_head_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    new_instr && scroll_en && !prev_q |=> line_cnt == $past(vscroll));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eol && !new_instr && !fetch_next |=>
      (fetch_next && $stable(line_cnt)) || (!fetch_next && line_cnt == $past(line_cnt) + ONE));

  p_first_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eol && !new_instr && !fetch_next |=> !fetch_data);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_next && !new_instr |=> fetch_next && $stable(line_cnt) && !fetch_data);

  p_quiet_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !new_instr && !eol |=> $stable(line_cnt) && $stable(fetch_next));
endmodule

bind vscroll_line_counter vsc_checker #(.CW(CW)) u_chk (.*);

// File: tb/tb_vscroll_line_counter.sv
module tb_vscroll_line_counter;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, new_instr, scroll_en, eol;
  logic [3:0] mode_last, vscroll;
  logic [3:0] line_cnt;
  logic       fetch_next, fetch_data;

  int n_chk = 0;
  int n_err = 0;
  bit prev_en = 1'b0;
  bit done = 1'b0;

  vscroll_line_counter dut (
    .clk(clk), .rst_n(rst_n), .new_instr(new_instr), .scroll_en(scroll_en),
    .mode_last(mode_last), .vscroll(vscroll), .eol(eol),
    .line_cnt(line_cnt), .fetch_next(fetch_next), .fetch_data(fetch_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int s, input int e);
    return ((e - s + 16) % 16) + 1;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // Starts a mode line and counts scanlines until the next-instruction request.
  task automatic run_line(input int ml, input bit en, input int vs, input bit collide);
    bit head, tail;
    int s, e, n;
    @(negedge clk);
    mode_last = 4'(ml); scroll_en = en; vscroll = 4'(vs);
    new_instr = 1'b1; eol = collide;
    @(negedge clk);
    new_instr = 1'b0; eol = 1'b0;
    head = en && !prev_en;   // R8
    tail = !en && prev_en;
    prev_en = en;
    s = head ? vs : 0;
    e = tail ? vs : ml;
    chk(int'(line_cnt) == s, head ? "R3 head start" : (collide ? "R9 load over eol" : "R2 start"),
        line_cnt, s);
    chk(fetch_next == 1'b0, "R2 request drops", fetch_next, 0);
    chk(fetch_data == 1'b1, "R6 first scanline", fetch_data, 1);
    n = 0;
    while (!fetch_next && n < 20) begin
      eol = 1'b1;
      @(negedge clk);
      eol = 1'b0;
      n++;
      if (n == 1) chk(fetch_data == 1'b0, "R6 fetch only once", fetch_data, 0);
    end
    chk(n == exp_len(s, e), "R10 line length", n, exp_len(s, e));
    chk(int'(line_cnt) == e, tail ? "R5 tail end" : "R4 end value", line_cnt, e);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    rst_n = 1'b0; new_instr = 1'b0; scroll_en = 1'b0; eol = 1'b0;
    mode_last = 4'd0; vscroll = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_cnt == 4'd0, "R1 reset count", line_cnt, 0);
    chk(fetch_next == 1'b1, "R1 reset request", fetch_next, 1);
    chk(fetch_data == 1'b0, "R1 reset fetch flag", fetch_data, 0);

    // R7: eol while request pending
    eol = 1'b1; @(negedge clk); eol = 1'b0;
    chk(line_cnt == 4'd0 && fetch_next, "R7 idle eol ignored", line_cnt, 0);

    // R10 example: one-scanline mode, scroll 13 -> 4 then 14 (R8: reset prev is clear)
    run_line(0, 1'b1, 13, 1'b0);
    run_line(0, 1'b0, 13, 1'b0);

    // sweep every scroll value: head, body, tail, plain
    for (int v = 0; v < 16; v++) begin
      run_line(int'($urandom % 16), 1'b1, v, 1'b0);
      run_line(int'($urandom % 16), 1'b1, v, 1'b0);
      run_line(int'($urandom % 16), 1'b0, v, 1'b0);
      run_line(int'($urandom % 16), 1'b0, v, 1'b0);
    end

    // R9: load and eol in the same cycle
    run_line(7, 1'b1, 2, 1'b1);
    run_line(3, 1'b0, 9, 1'b1);

    // R5: scroll written during a tail line
    run_line(5, 1'b1, 4, 1'b0);
    @(negedge clk);
    mode_last = 4'd7; scroll_en = 1'b0; vscroll = 4'd13; new_instr = 1'b1;
    @(negedge clk);
    new_instr = 1'b0; prev_en = 1'b0;
    repeat (2) begin eol = 1'b1; @(negedge clk); eol = 1'b0; end
    vscroll = 4'd2;
    n = 2;
    while (!fetch_next && n < 20) begin
      eol = 1'b1; @(negedge clk); eol = 1'b0; n++;
    end
    chk(n == 3, "R5 live scroll length", n, 3);

    // R7: eol after completion changes nothing
    eol = 1'b1; @(negedge clk); eol = 1'b0;
    chk(line_cnt == 4'd2 && fetch_next, "R7 eol ignored", line_cnt, 2);

    // constrained random runs
    for (int k = 0; k < 80; k++)
      run_line(int'($urandom % 16), 1'($urandom % 2), int'($urandom % 16), 1'($urandom % 4 == 0));

    finish_run();
  end
endmodule